// File: doc/BRIEF.md
# Chained Source Fetcher

This block is a read-only DMA source that reads a byte stream from memory and presents it, one 32-bit word per beat, to a downstream consumer such as a hash core. Software sets it up through a small write-only register port. In buffer mode it reads one contiguous region, given by a start address and a byte count. In chained mode it reads a list of descriptors held in memory. Each descriptor is four consecutive words: data address, byte count, address of the following descriptor, and a flag word. Bit 31 of the flag word ends the list.

Starting a transfer takes two writes. First a command write arms the block. Then a mode write with the enable bit set starts it. Memory is reached through a request/response read port with one read outstanding at a time. Data leaves through a valid/ready stream that carries a byte-enable. When the consumer accepts the final beat, the block pulses a done strobe. A read error stops the walk and pulses an error strobe instead. Clearing the enable bit while a transfer runs stops it at the next request boundary, and no done pulse follows.

Register word offsets on the configuration port: 0 = command (bit 0 arms), 1 = mode (bit 0 enable, bit 1 chained mode, bits 6:4 bus attributes), 2 = buffer address, 3 = buffer byte count, 4 = address of the first descriptor.

Top module: `chain_src_fetch`

## Requirements
- R1: After reset the block is idle: busy, memReqValid, outValid, doneP and errP are all 0.
- R2: A mode write with bit 0 set starts a transfer only if a command write with bit 0 set came before it and no transfer has consumed that arming since. Without arming, no memory request is made and busy stays 0.
- R3: In buffer mode the block reads words at ascending addresses, starting at the buffer address and stepping by 4. It delivers ceil(count/4) beats, and each beat's data equals the memory word read for it.
- R4: outByteEn is 4'b1111 on every beat except a segment's last beat when count mod 4 is 1, 2 or 3. That last beat carries 4'b0001, 4'b0011 or 4'b0111 respectively.
- R5: In chained mode each descriptor is read as four requests at its address +0, +4, +8 and +12. The words are taken as data address, byte count, next address and flag word, in that order. The data reads for the descriptor follow.
- R6: After a descriptor whose flag word has bit 31 clear, the block reads the descriptor at its next address. When bit 31 is set, the walk ends after that descriptor and its next address is never read.
- R7: A descriptor with byte count 0 causes no data reads and no beats. The walk then continues with the next descriptor, or ends if bit 31 is set.
- R8: doneP is high for exactly one cycle, the cycle after the consumer accepts the final beat. outLast is high on that final beat only. A buffer-mode transfer with count 0 pulses doneP and delivers no beats.
- R9: An error response to any read pulses errP for one cycle. No doneP follows, no further request is issued, and the block returns to idle.
- R10: A mode write with bit 0 clear during a transfer lets the current read or beat finish. The block then returns to idle without a further request and without doneP.
- R11: While outReady is low, outValid, outData and outByteEn hold their values. While memReqReady is low, memReqValid and memReqAddr hold theirs.
- R12: memReqAttr equals mode bits 6:4 from the most recent mode write, on every request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWr | input | 1 | Configuration write strobe |
| cfgAddr | input | 3 | Configuration word offset |
| cfgData | input | 32 | Configuration write data |
| memReqValid | output | 1 | Read request valid |
| memReqReady | input | 1 | Read request accepted |
| memReqAddr | output | ADDR_W | Read byte address, word aligned |
| memReqAttr | output | 3 | Bus attribute bits for the request |
| memRspValid | input | 1 | Read response valid |
| memRspData | input | 32 | Read response word |
| memRspErr | input | 1 | Read response carries an error |
| outValid | output | 1 | Stream beat valid |
| outReady | input | 1 | Consumer accepts the beat |
| outData | output | 32 | Stream data word |
| outByteEn | output | 4 | Valid bytes of the beat |
| outLast | output | 1 | Final beat of the transfer |
| busy | output | 1 | Transfer in progress |
| doneP | output | 1 | All bytes delivered pulse |
| errP | output | 1 | Read error pulse |

## Verification
The assertions take for granted that the buffer address, descriptor addresses and descriptor data addresses are all multiples of four. They also assume the memory returns exactly one response for each accepted request and never returns one unasked. The bench's memory model follows that discipline: one response, one cycle after acceptance. Every address it programs, whether through the register port or inside a descriptor, is word aligned. The stall pattern toggles memReqReady and outReady on alternate cycles, which exercises the hold properties without breaking the one-outstanding-read rule.

// File: rtl/chain_src_fetch_pkg.sv
package chain_src_fetch_pkg;

  localparam int CFG_AW = 3;
  localparam int REG_CMD = 0;
  localparam int REG_MODE = 1;
  localparam int REG_BUFADDR = 2;
  localparam int REG_BUFLEN = 3;
  localparam int REG_HEAD = 4;

  localparam int MODE_EN_BIT = 0;
  localparam int MODE_CHAIN_BIT = 1;
  localparam int MODE_ATTR_LSB = 4;
  localparam int ATTR_W = 3;
  localparam int TERM_BIT = 31;
  localparam int WORD_W = 32;
  localparam int BE_W = WORD_W / 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEG,
    ST_DREQ,
    ST_DWAIT,
    ST_RREQ,
    ST_RWAIT,
    ST_BEAT
  } fetchStateT;

  typedef struct packed {
    logic consumeArm;
    logic loadDirect;
    logic loadChain;
    logic capDesc;
    logic followNext;
    logic capData;
    logic advance;
    logic selDesc;
  } fetchCtlT;

endpackage

// File: rtl/chain_src_fetch_dp.sv
module chain_src_fetch_dp
  import chain_src_fetch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [WORD_W-1:0] cfgData,
  input  fetchCtlT          ctl,
  input  logic [WORD_W-1:0] memRspData,
  output logic              startHit,
  output logic              startChain,
  output logic              abortReq,
  output logic              remZero,
  output logic              lastBeat,
  output logic              termSet,
  output logic              descLast,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [ATTR_W-1:0] memReqAttr,
  output logic [WORD_W-1:0] outData,
  output logic [BE_W-1:0]   outByteEn
);

  localparam int WORD_BYTES = WORD_W / 8;
  localparam logic [LEN_W-1:0] WORD_LEN = LEN_W'(WORD_BYTES);
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(WORD_BYTES);
  localparam int IDX_W = 2;

  // software-visible setup
  logic              armed;
  logic              modeEn;
  logic [ATTR_W-1:0] attrR;
  logic [ADDR_W-1:0] bufAddrR;
  logic [LEN_W-1:0]  bufLenR;
  logic [ADDR_W-1:0] headR;

  // working state of the walk
  logic [ADDR_W-1:0] curAddr;
  logic [LEN_W-1:0]  remLen;
  logic [ADDR_W-1:0] nextPtr;
  logic [ADDR_W-1:0] descPtr;
  logic              termFlag;
  logic [IDX_W-1:0]  wordIdx;
  logic [WORD_W-1:0] dataR;

  logic modeWr;
  assign modeWr = cfgWr && (cfgAddr == CFG_AW'(REG_MODE));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed    <= 1'b0;
      modeEn   <= 1'b0;
      attrR    <= '0;
      bufAddrR <= '0;
      bufLenR  <= '0;
      headR    <= '0;
    end else begin
      if (cfgWr) begin
        case (cfgAddr)
          CFG_AW'(REG_CMD):     if (cfgData[0]) armed <= 1'b1;
          CFG_AW'(REG_MODE): begin
            modeEn <= cfgData[MODE_EN_BIT];
            attrR  <= cfgData[MODE_ATTR_LSB +: ATTR_W];
          end
          CFG_AW'(REG_BUFADDR): bufAddrR <= cfgData[ADDR_W-1:0];
          CFG_AW'(REG_BUFLEN):  bufLenR  <= cfgData[LEN_W-1:0];
          CFG_AW'(REG_HEAD):    headR    <= cfgData[ADDR_W-1:0];
          default: ;
        endcase
      end
      if (ctl.consumeArm) armed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr  <= '0;
      remLen   <= '0;
      nextPtr  <= '0;
      descPtr  <= '0;
      termFlag <= 1'b0;
      wordIdx  <= '0;
      dataR    <= '0;
    end else begin
      if (ctl.loadDirect) begin
        curAddr  <= bufAddrR;
        remLen   <= bufLenR;
        termFlag <= 1'b1;
      end
      if (ctl.loadChain) begin
        descPtr <= headR;
        wordIdx <= '0;
      end
      if (ctl.followNext) begin
        descPtr <= nextPtr;
        wordIdx <= '0;
      end
      if (ctl.capDesc) begin
        case (wordIdx)
          2'd0:    curAddr  <= memRspData[ADDR_W-1:0];
          2'd1:    remLen   <= memRspData[LEN_W-1:0];
          2'd2:    nextPtr  <= memRspData[ADDR_W-1:0];
          default: termFlag <= memRspData[TERM_BIT];
        endcase
        wordIdx <= wordIdx + 1'b1;
      end
      if (ctl.capData) dataR <= memRspData;
      if (ctl.advance) begin
        curAddr <= curAddr + WORD_STEP;
        remLen  <= lastBeat ? '0 : remLen - WORD_LEN;
      end
    end
  end

  assign startHit   = modeWr && cfgData[MODE_EN_BIT] && armed;
  assign startChain = cfgData[MODE_CHAIN_BIT];
  assign abortReq   = !modeEn;
  assign remZero    = (remLen == '0);
  assign lastBeat   = (remLen <= WORD_LEN);
  assign termSet    = termFlag;
  assign descLast   = (wordIdx == IDX_W'(3));

  assign memReqAddr = ctl.selDesc ? descPtr + ADDR_W'({wordIdx, 2'b00}) : curAddr;
  assign memReqAttr = attrR;
  assign outData    = dataR;

  always_comb begin
    if (remLen >= WORD_LEN) begin
      outByteEn = '1;
    end else begin
      case (remLen[1:0])
        2'd1:    outByteEn = 4'b0001;
        2'd2:    outByteEn = 4'b0011;
        2'd3:    outByteEn = 4'b0111;
        default: outByteEn = 4'b1111;
      endcase
    end
  end

endmodule

// File: rtl/chain_src_fetch_ctl.sv
module chain_src_fetch_ctl
  import chain_src_fetch_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startHit,
  input  logic     startChain,
  input  logic     abortReq,
  input  logic     remZero,
  input  logic     lastBeat,
  input  logic     termSet,
  input  logic     descLast,
  input  logic     memReqReady,
  input  logic     memRspValid,
  input  logic     memRspErr,
  input  logic     outReady,
  output fetchCtlT ctl,
  output logic     memReqValid,
  output logic     outValid,
  output logic     outLast,
  output logic     busy,
  output logic     doneP,
  output logic     errP
);

  fetchStateT state, nextState;
  logic finish, fail;

  always_comb begin
    nextState   = state;
    ctl         = '0;
    memReqValid = 1'b0;
    outValid    = 1'b0;
    finish      = 1'b0;
    fail        = 1'b0;
    case (state)
      ST_IDLE: begin
        if (startHit) begin
          ctl.consumeArm = 1'b1;
          if (startChain) begin
            ctl.loadChain = 1'b1;
            nextState     = ST_DREQ;
          end else begin
            ctl.loadDirect = 1'b1;
            nextState      = ST_SEG;
          end
        end
      end
      ST_SEG: begin
        if (abortReq) begin
          nextState = ST_IDLE;
        end else if (remZero) begin
          if (termSet) begin
            finish    = 1'b1;
            nextState = ST_IDLE;
          end else begin
            ctl.followNext = 1'b1;
            nextState      = ST_DREQ;
          end
        end else begin
          nextState = ST_RREQ;
        end
      end
      ST_DREQ: begin
        ctl.selDesc = 1'b1;
        memReqValid = 1'b1;
        if (memReqReady) nextState = ST_DWAIT;
      end
      ST_DWAIT: begin
        ctl.selDesc = 1'b1;
        if (memRspValid) begin
          if (memRspErr) begin
            fail      = 1'b1;
            nextState = ST_IDLE;
          end else begin
            ctl.capDesc = 1'b1;
            if (descLast)      nextState = ST_SEG;
            else if (abortReq) nextState = ST_IDLE;
            else               nextState = ST_DREQ;
          end
        end
      end
      ST_RREQ: begin
        memReqValid = 1'b1;
        if (memReqReady) nextState = ST_RWAIT;
      end
      ST_RWAIT: begin
        if (memRspValid) begin
          if (memRspErr) begin
            fail      = 1'b1;
            nextState = ST_IDLE;
          end else begin
            ctl.capData = 1'b1;
            nextState   = ST_BEAT;
          end
        end
      end
      ST_BEAT: begin
        outValid = 1'b1;
        if (outReady) begin
          ctl.advance = 1'b1;
          if (abortReq) begin
            nextState = ST_IDLE;
          end else if (lastBeat) begin
            if (termSet) begin
              finish    = 1'b1;
              nextState = ST_IDLE;
            end else begin
              ctl.followNext = 1'b1;
              nextState      = ST_DREQ;
            end
          end else begin
            nextState = ST_RREQ;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      doneP <= 1'b0;
      errP  <= 1'b0;
    end else begin
      state <= nextState;
      doneP <= finish;
      errP  <= fail;
    end
  end

  assign busy    = (state != ST_IDLE);
  assign outLast = (state == ST_BEAT) && lastBeat && termSet;

endmodule

// File: rtl/chain_src_fetch.sv
module chain_src_fetch
  import chain_src_fetch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic [2:0]        cfgAddr,
  input  logic [31:0]       cfgData,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [2:0]        memReqAttr,
  input  logic              memRspValid,
  input  logic [31:0]       memRspData,
  input  logic              memRspErr,
  output logic              outValid,
  input  logic              outReady,
  output logic [31:0]       outData,
  output logic [3:0]        outByteEn,
  output logic              outLast,
  output logic              busy,
  output logic              doneP,
  output logic              errP
);

  fetchCtlT ctl;
  logic startHit, startChain, abortReq, remZero, lastBeat, termSet, descLast;

  chain_src_fetch_dp #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWr      (cfgWr),
    .cfgAddr    (cfgAddr),
    .cfgData    (cfgData),
    .ctl        (ctl),
    .memRspData (memRspData),
    .startHit   (startHit),
    .startChain (startChain),
    .abortReq   (abortReq),
    .remZero    (remZero),
    .lastBeat   (lastBeat),
    .termSet    (termSet),
    .descLast   (descLast),
    .memReqAddr (memReqAddr),
    .memReqAttr (memReqAttr),
    .outData    (outData),
    .outByteEn  (outByteEn)
  );

  chain_src_fetch_ctl i_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .startHit    (startHit),
    .startChain  (startChain),
    .abortReq    (abortReq),
    .remZero     (remZero),
    .lastBeat    (lastBeat),
    .termSet     (termSet),
    .descLast    (descLast),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .memRspErr   (memRspErr),
    .outReady    (outReady),
    .ctl         (ctl),
    .memReqValid (memReqValid),
    .outValid    (outValid),
    .outLast     (outLast),
    .busy        (busy),
    .doneP       (doneP),
    .errP        (errP)
  );

endmodule

// File: rtl/chain_src_fetch_chk.sv
module chain_src_fetch_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWr,
  input logic [2:0]        cfgAddr,
  input logic [31:0]       cfgData,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              outValid,
  input logic              outReady,
  input logic [31:0]       outData,
  input logic [3:0]        outByteEn,
  input logic              outLast,
  input logic              busy,
  input logic              doneP,
  input logic              errP
);

  AST_START_CMD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cfgWr && cfgAddr == 3'd1 && cfgData[0])); // R2

  AST_REQ_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> memReqAddr[1:0] == 2'b00); // R5

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr)); // R11

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outByteEn)); // R11

  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outByteEn == 4'b0001 || outByteEn == 4'b0011 ||
                  outByteEn == 4'b0111 || outByteEn == 4'b1111)); // R4

  AST_BE_LAST_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outByteEn != 4'b1111 && outReady |=> !outValid); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    doneP |=> !doneP); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    doneP |-> !busy && !errP); // R8

  AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid); // R8

  AST_ERR_STOP: assert property (@(posedge clk) disable iff (!rstN)
    errP |-> !busy && !memReqValid); // R9

endmodule

bind chain_src_fetch chain_src_fetch_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cfgWr       (cfgWr),
  .cfgAddr     (cfgAddr),
  .cfgData     (cfgData),
  .memReqValid (memReqValid),
  .memReqReady (memReqReady),
  .memReqAddr  (memReqAddr),
  .outValid    (outValid),
  .outReady    (outReady),
  .outData     (outData),
  .outByteEn   (outByteEn),
  .outLast     (outLast),
  .busy        (busy),
  .doneP       (doneP),
  .errP        (errP)
);

// File: tb/test_chain_src_fetch.sv
module test_chain_src_fetch;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWr = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [31:0] cfgData = '0;
  logic        memReqValid;
  logic        memReqReady = 1'b1;
  logic [31:0] memReqAddr;
  logic [2:0]  memReqAttr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        memRspErr = 1'b0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [31:0] outData;
  logic [3:0]  outByteEn;
  logic        outLast;
  logic        busy, doneP, errP;

  always #4 clk = ~clk;  // 125 MHz

  chain_src_fetch i_chain_src_fetch (.*);

  // memory model and stream sink
  logic [31:0] memArr [0:511];
  logic [31:0] errAddr = '0;
  logic        errEn = 1'b0;
  int          sinkMode = 0;  // 0 always ready, 1 toggle, 2 held low
  logic        pend = 1'b0;
  logic [31:0] pAddr = '0;
  int cyc = 0;
  int reqCnt = 0, beatCnt = 0, doneCnt = 0, errCnt = 0;
  int lastBeatCyc = 0, doneCyc = 0;
  logic [31:0] reqLog [0:63];
  logic [2:0]  attrLog [0:63];
  logic [31:0] beatData [0:63];
  logic [3:0]  beatBe [0:63];
  logic        beatLast [0:63];
  int nChk = 0, nFail = 0;

  always @(negedge clk) begin
    cyc++;
    memRspValid = 1'b0;
    memRspErr   = 1'b0;
    if (pend) begin
      memRspValid = 1'b1;
      memRspData  = memArr[pAddr[10:2]];
      memRspErr   = errEn && (pAddr == errAddr);
      pend        = 1'b0;
    end
    memReqReady = (sinkMode == 1) ? ~memReqReady : 1'b1;
    outReady    = (sinkMode == 0) ? 1'b1 : (sinkMode == 1) ? ~outReady : 1'b0;
    if (rstN && memReqValid && memReqReady) begin
      if (reqCnt < 64) begin
        reqLog[reqCnt]  = memReqAddr;
        attrLog[reqCnt] = memReqAttr;
      end
      reqCnt++;
      pend  = 1'b1;
      pAddr = memReqAddr;
    end
    if (rstN && outValid && outReady) begin
      if (beatCnt < 64) begin
        beatData[beatCnt] = outData;
        beatBe[beatCnt]   = outByteEn;
        beatLast[beatCnt] = outLast;
      end
      beatCnt++;
      if (outLast) lastBeatCyc = cyc;
    end
    if (doneP) begin doneCnt++; doneCyc = cyc; end
    if (errP) errCnt++;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWr = 1'b1; cfgAddr = a; cfgData = d;
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  task automatic clearLogs();
    @(posedge clk);
    reqCnt = 0; beatCnt = 0; doneCnt = 0; errCnt = 0;
  endtask

  task automatic waitEnd();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (doneCnt + errCnt > 0) break;
    end
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [3:0] expBe(input int len);
    case (len % 4)
      1: return 4'b0001;
      2: return 4'b0011;
      3: return 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk(busy == 0 && memReqValid == 0 && outValid == 0 && doneP == 0 && errP == 0,
        "R1 reset idle", {busy, memReqValid, outValid, doneP, errP}, 0);
  endtask

  task automatic t_noarm();
    clearLogs();
    cfgWrite(3'd2, 32'h100);
    cfgWrite(3'd3, 32'd8);
    cfgWrite(3'd1, 32'h1);
    repeat (10) @(negedge clk);
    chk(busy == 0 && reqCnt == 0, "R2 no start without arming", reqCnt, 0);
    cfgWrite(3'd1, 32'h0);
  endtask

  task automatic t_direct(input logic [31:0] base, input int len, input logic [2:0] attr, input int mode);
    int nb;
    clearLogs();
    sinkMode = mode;
    cfgWrite(3'd2, base);
    cfgWrite(3'd3, len);
    cfgWrite(3'd0, 32'h1);
    cfgWrite(3'd1, {25'd0, attr, 4'b0001});
    waitEnd();
    nb = (len + 3) / 4;
    chk(beatCnt == nb, "R3 beat count", beatCnt, nb);
    chk(reqCnt == nb, "R3 request count", reqCnt, nb);
    for (int i = 0; i < nb && i < 64; i++) begin
      chk(reqLog[i] == base + 4 * i, "R3 request address", reqLog[i], base + 4 * i);
      chk(beatData[i] == memArr[(base >> 2) + i], "R3 beat data", beatData[i], memArr[(base >> 2) + i]);
      chk(beatBe[i] == ((i == nb - 1) ? expBe(len) : 4'hF), "R4 byte enable", beatBe[i],
          (i == nb - 1) ? expBe(len) : 4'hF);
      chk(beatLast[i] == (i == nb - 1), "R8 last flag", beatLast[i], i == nb - 1);
      chk(attrLog[i] == attr, "R12 attribute", attrLog[i], attr);
    end
    chk(doneCnt == 1 && errCnt == 0, "R8 single done", doneCnt, 1);
    if (nb > 0) chk(doneCyc - lastBeatCyc == 1, "R8 done timing", doneCyc - lastBeatCyc, 1);
    chk(busy == 0, "R8 idle after done", busy, 0);
    sinkMode = 0;
    cfgWrite(3'd1, 32'h0);
  endtask

  task automatic buildChain();
    memArr[32'h100 >> 2] = 32'h400; memArr[32'h104 >> 2] = 32'd6;
    memArr[32'h108 >> 2] = 32'h120; memArr[32'h10C >> 2] = 32'h0;
    memArr[32'h120 >> 2] = 32'h480; memArr[32'h124 >> 2] = 32'd0;
    memArr[32'h128 >> 2] = 32'h140; memArr[32'h12C >> 2] = 32'h0;
    memArr[32'h140 >> 2] = 32'h500; memArr[32'h144 >> 2] = 32'd5;
    memArr[32'h148 >> 2] = 32'h1F0; memArr[32'h14C >> 2] = 32'h8000_0000;
  endtask

  task automatic t_chain(input int mode);
    logic [31:0] er [0:15];
    logic [31:0] ed [0:3];
    logic [3:0]  eb [0:3];
    er = '{32'h100, 32'h104, 32'h108, 32'h10C, 32'h400, 32'h404,
           32'h120, 32'h124, 32'h128, 32'h12C,
           32'h140, 32'h144, 32'h148, 32'h14C, 32'h500, 32'h504};
    ed = '{memArr[32'h400 >> 2], memArr[32'h404 >> 2], memArr[32'h500 >> 2], memArr[32'h504 >> 2]};
    eb = '{4'hF, 4'h3, 4'hF, 4'h1};
    clearLogs();
    sinkMode = mode;
    cfgWrite(3'd4, 32'h100);
    cfgWrite(3'd0, 32'h1);
    cfgWrite(3'd1, 32'h3);
    waitEnd();
    chk(reqCnt == 16, "R5 R6 R7 request count", reqCnt, 16);
    for (int i = 0; i < 16; i++)
      chk(reqLog[i] == er[i], "R5 R6 R7 request order", reqLog[i], er[i]);
    chk(beatCnt == 4, "R7 beat count", beatCnt, 4);
    for (int i = 0; i < 4; i++) begin
      chk(beatData[i] == ed[i], "R5 R11 chain data", beatData[i], ed[i]);
      chk(beatBe[i] == eb[i], "R4 chain byte enable", beatBe[i], eb[i]);
      chk(beatLast[i] == (i == 3), "R8 chain last", beatLast[i], i == 3);
    end
    chk(doneCnt == 1, "R6 done after terminate", doneCnt, 1);
    sinkMode = 0;
    cfgWrite(3'd1, 32'h0);
  endtask

  task automatic t_error();
    clearLogs();
    errEn = 1'b1; errAddr = 32'h404;
    cfgWrite(3'd4, 32'h100);
    cfgWrite(3'd0, 32'h1);
    cfgWrite(3'd1, 32'h3);
    waitEnd();
    repeat (10) @(negedge clk);
    chk(errCnt == 1 && doneCnt == 0, "R9 error pulse without done", {errCnt[15:0], doneCnt[15:0]}, 32'h0001_0000);
    chk(reqCnt == 6, "R9 no request after error", reqCnt, 6);
    chk(reqLog[5] == 32'h404, "R9 last request", reqLog[5], 32'h404);
    chk(beatCnt == 1 && busy == 0, "R9 idle after error", beatCnt, 1);
    errEn = 1'b0;
    cfgWrite(3'd1, 32'h0);
  endtask

  task automatic t_abort();
    clearLogs();
    sinkMode = 2;
    cfgWrite(3'd2, 32'h200);
    cfgWrite(3'd3, 32'd64);
    cfgWrite(3'd0, 32'h1);
    cfgWrite(3'd1, 32'h1);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (outValid) break;
    end
    cfgWrite(3'd1, 32'h0);
    @(posedge clk);
    sinkMode = 0;
    repeat (20) @(negedge clk);
    chk(beatCnt == 1, "R10 held beat completes then stops", beatCnt, 1);
    chk(reqCnt == 1, "R10 no request after abort", reqCnt, 1);
    chk(doneCnt == 0 && errCnt == 0, "R10 no done on abort", doneCnt, 0);
    chk(busy == 0, "R10 idle after abort", busy, 0);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) memArr[i] = {i[7:0] ^ 8'h5A, 8'hC3, 7'd0, i[8:0]};
    buildChain();
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_noarm();
    t_direct(32'h040, 10, 3'd5, 0);
    t_direct(32'h080, 8, 3'd2, 1);
    t_direct(32'h0C0, 1, 3'd7, 0);
    t_direct(32'h0E0, 7, 3'd0, 1);
    t_direct(32'h060, 0, 3'd1, 0);
    t_chain(0);
    t_chain(1);
    t_error();
    t_abort();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule